// File: doc/BRIEF.md
# Strap-Sampled Boost Configuration Controller

This block holds the equalizer settings of a high-speed signal conditioner. While the active-low reset pin is low, it takes the decoded strap levels on every clock: a four-level AC-boost strap with an "open" flag, a three-level DC-boost strap, and the levels of the two serial bus lines. The last value taken before reset rises is kept. The serial-line levels choose the access mode. If both lines were high, the block runs in serial-register mode. Otherwise it runs in pin-strap mode.

In serial-register mode, a bus target front end reaches three registers through a request/response port. Those registers are the AC-boost code, the DC-boost code and a configuration-hold bit. While the hold bit is set, the downstream state machine is kept disabled and the applied boost codes follow the registers. When software clears the bit, the state machine starts and the applied codes freeze. To apply new codes, software sets the bit and then clears it again. In pin-strap mode the register port has no effect. The hold bit clears by itself on the first clock after reset is released.

The request port is valid/ready. `req_ready` is high whenever reset is released and low during reset, so a request is taken on any clock edge where `req_valid` and `req_ready` are both high. The front end applies back-pressure only by keeping `req_valid` low. Responses cannot be stalled.

Top module: `strap_cfg_ctrl`

## Requirements
- R1: On any clock edge with `rst_pin_n` low, the following happen within that one clock: the registers load their strap-derived defaults, the hold bit is set, `sm_enable` goes low, `req_ready` is low, and `ac_boost`/`dc_boost` show the encoded strap levels.
- R2: `serial_mode` is 1 only when `scl_lvl` and `sda_lvl` were both 1 on the last clock edge of reset. If either line was 0, the block is in pin-strap mode.
- R3: Strap and serial-line inputs are ignored while reset is released. Changing them has no effect on any output until the next reset.
- R4: The AC-boost code is a thermometer code: level 0 is 000, 1 is 001, 2 is 011 and 3 is 111 (from `ac_strap_lvl` 0..3). When `ac_strap_open` is high, the code is 111. The code is read and written at offset 0x01, bits 6:4.
- R5: The DC-boost code is taken from `dc_strap_lvl`. Low (0) gives 011, mid (1) gives 101, and high (2) gives 111. The value 3 is treated as mid. The code is read and written at offset 0x03 ^ 0x0D = offset 0x0E, bits 2:0.
- R6: The hold bit is at offset 0x03, bit 0, and resets to 1. `sm_enable` is the inverse of the hold bit. In pin-strap mode the hold bit clears on the first clock after reset release. In serial mode it stays at 1 until a register write clears it.
- R7: While the hold bit is 1, `ac_boost`/`dc_boost` take the register values one clock after they change. While the hold bit is 0, they hold their values.
- R8: A request has effect only if it is accepted in serial mode with `req_dev` equal to the 7-bit target address 0x2C. Any other accepted request is dropped: no register changes and no response is produced.
- R9: An effective read produces `rsp_valid` for one cycle, together with `rsp_rdata`, on the clock edge that accepts it. Undefined offsets read 0. Reserved bits read 0 and are unaffected by writes.
- R10: A write that carries an AC code other than 000/001/011/111, or a DC code other than 011/101/111, leaves that field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Active-low reset/enable pin; straps are sampled while low |
| ac_strap_lvl | input | 2 | Decoded AC-boost strap level 0..3 |
| ac_strap_open | input | 1 | AC-boost strap left open (selects max level) |
| dc_strap_lvl | input | 2 | Decoded DC-boost strap: 0 low, 1 mid, 2 high |
| scl_lvl | input | 1 | Serial clock line level |
| sda_lvl | input | 1 | Serial data line level |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 write, 0 read |
| req_dev | input | 7 | Target address of the request |
| req_addr | input | 8 | Register offset |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 8 | Read data |
| serial_mode | output | 1 | 1 when serial-register mode was chosen at reset |
| sm_enable | output | 1 | Main state machine enable |
| ac_boost | output | 3 | Applied AC-boost code |
| dc_boost | output | 3 | Applied DC-boost code |

## Verification
The timing of each result is fixed relative to the clock edge that causes it:
- Register contents, `sm_enable` and read responses change on the edge that accepts the request.
- The applied boost codes change one edge later.
- The reset values and the mode appear on the first edge taken while reset is low or just released.

The bench drives every input on the falling edge. It samples 1 ns after the rising edge at which a result is due. For the applied codes it waits one further rising edge before sampling.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    DC_LOW  = 2'd0,
    DC_MID  = 2'd1,
    DC_HIGH = 2'd2,
    DC_RSVD = 2'd3
  } dc_lvl_e;

  // Thermometer code for the AC-boost strap level
  function automatic code_t ac_encode(input logic [1:0] lvl, input logic open_pin);
    code_t c;
    if (open_pin) c = 3'b111;
    else begin
      case (lvl)
        2'd0:    c = 3'b000;
        2'd1:    c = 3'b001;
        2'd2:    c = 3'b011;
        default: c = 3'b111;
      endcase
    end
    return c;
  endfunction

  function automatic code_t dc_encode(input logic [1:0] lvl);
    code_t c;
    case (dc_lvl_e'(lvl))
      DC_LOW:  c = 3'b011;
      DC_HIGH: c = 3'b111;
      default: c = 3'b101;
    endcase
    return c;
  endfunction

  function automatic logic ac_legal(input code_t c);
    return (c & (c + 3'd1)) == 3'd0;
  endfunction

  function automatic logic dc_legal(input code_t c);
    return (c == 3'b011) || (c == 3'b101) || (c == 3'b111);
  endfunction
endpackage

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_pin_n,
  input  logic [1:0] ac_strap_lvl,
  input  logic       ac_strap_open,
  input  logic [1:0] dc_strap_lvl,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  output logic       serial_mode,
  output code_t      def_ac,
  output code_t      def_dc
);
  logic serial_q;

  // Mode follows the bus lines on every reset edge; the last one sticks
  always_ff @(posedge clk) begin
    if (!rst_pin_n) serial_q <= scl_lvl & sda_lvl;
  end

  assign serial_mode = serial_q;
  assign def_ac      = ac_encode(ac_strap_lvl, ac_strap_open);
  assign def_dc      = dc_encode(dc_strap_lvl);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import strap_cfg_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 8,
  parameter int                DEV_W    = 7,
  parameter logic [DEV_W-1:0]  DEV_ADDR = 7'h2C,
  parameter logic [ADDR_W-1:0] AC_OFS   = 8'h01,
  parameter int                AC_LSB   = 4,
  parameter logic [ADDR_W-1:0] HOLD_OFS = 8'h03,
  parameter int                HOLD_BIT = 0,
  parameter logic [ADDR_W-1:0] DC_OFS   = 8'h0E,
  parameter int                DC_LSB   = 0
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              serial_mode,
  input  code_t             def_ac,
  input  code_t             def_dc,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output code_t             ac_q,
  output code_t             dc_q,
  output logic              hold_q
);
  localparam int AC_MSB = AC_LSB + CODE_W - 1;
  localparam int DC_MSB = DC_LSB + CODE_W - 1;

  logic              hit, rd_hit, wr_hit;
  logic [DATA_W-1:0] rd_mux;
  code_t             wr_ac, wr_dc;
  logic              unused_wdata;

  assign req_ready = rst_pin_n;
  assign hit       = req_valid && req_ready && serial_mode && (req_dev == DEV_ADDR);
  assign rd_hit    = hit && !req_write;
  assign wr_hit    = hit && req_write;
  assign wr_ac     = req_wdata[AC_MSB:AC_LSB];
  assign wr_dc     = req_wdata[DC_MSB:DC_LSB];
  assign unused_wdata = ^req_wdata;

  always_comb begin
    rd_mux = '0;
    if (req_addr == AC_OFS)        rd_mux[AC_MSB:AC_LSB] = ac_q;
    else if (req_addr == DC_OFS)   rd_mux[DC_MSB:DC_LSB] = dc_q;
    else if (req_addr == HOLD_OFS) rd_mux[HOLD_BIT]      = hold_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_pin_n) begin
      ac_q      <= def_ac;
      dc_q      <= def_dc;
      hold_q    <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_hit;
      if (rd_hit) rsp_rdata <= rd_mux;
      if (!serial_mode) hold_q <= 1'b0;
      if (wr_hit) begin
        if (req_addr == AC_OFS && ac_legal(wr_ac))  ac_q   <= wr_ac;
        if (req_addr == DC_OFS && dc_legal(wr_dc))  dc_q   <= wr_dc;
        if (req_addr == HOLD_OFS)                   hold_q <= req_wdata[HOLD_BIT];
      end
    end
  end
endmodule

// File: rtl/cfg_apply.sv
module cfg_apply
  import strap_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_pin_n,
  input  code_t def_ac,
  input  code_t def_dc,
  input  code_t ac_q,
  input  code_t dc_q,
  input  logic  hold_q,
  output code_t ac_out,
  output code_t dc_out
);
  // Applied codes follow the registers only while configuration is held
  always_ff @(posedge clk) begin
    if (!rst_pin_n) begin
      ac_out <= def_ac;
      dc_out <= def_dc;
    end else if (hold_q) begin
      ac_out <= ac_q;
      dc_out <= dc_q;
    end
  end
endmodule

// File: rtl/strap_cfg_ctrl.sv
module strap_cfg_ctrl
  import strap_cfg_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter int               ADDR_W   = 8,
  parameter int               DEV_W    = 7,
  parameter logic [DEV_W-1:0] DEV_ADDR = 7'h2C
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic [1:0]        ac_strap_lvl,
  input  logic              ac_strap_open,
  input  logic [1:0]        dc_strap_lvl,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              serial_mode,
  output logic              sm_enable,
  output logic [2:0]        ac_boost,
  output logic [2:0]        dc_boost
);
  code_t def_ac, def_dc, ac_q, dc_q;
  logic  hold_q;

  strap_sampler u_smp (
    .clk           (clk),
    .rst_pin_n     (rst_pin_n),
    .ac_strap_lvl  (ac_strap_lvl),
    .ac_strap_open (ac_strap_open),
    .dc_strap_lvl  (dc_strap_lvl),
    .scl_lvl       (scl_lvl),
    .sda_lvl       (sda_lvl),
    .serial_mode   (serial_mode),
    .def_ac        (def_ac),
    .def_dc        (def_dc)
  );

  cfg_regfile #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .DEV_W    (DEV_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_rf (
    .clk         (clk),
    .rst_pin_n   (rst_pin_n),
    .serial_mode (serial_mode),
    .def_ac      (def_ac),
    .def_dc      (def_dc),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_dev     (req_dev),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .ac_q        (ac_q),
    .dc_q        (dc_q),
    .hold_q      (hold_q)
  );

  cfg_apply u_app (
    .clk       (clk),
    .rst_pin_n (rst_pin_n),
    .def_ac    (def_ac),
    .def_dc    (def_dc),
    .ac_q      (ac_q),
    .dc_q      (dc_q),
    .hold_q    (hold_q),
    .ac_out    (ac_boost),
    .dc_out    (dc_boost)
  );

  assign sm_enable = rst_pin_n & ~hold_q;
endmodule

// File: rtl/strap_cfg_checker.sv
module strap_cfg_checker #(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input logic       clk,
  input logic       rst_pin_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [6:0] req_dev,
  input logic       rsp_valid,
  input logic       serial_mode,
  input logic       sm_enable,
  input logic [2:0] ac_boost,
  input logic [2:0] dc_boost
);
  logic in_rst_q = 1'b0;
  logic rd_take, wr_take;

  assign rd_take = req_valid && req_ready && !req_write && serial_mode && (req_dev == DEV_ADDR);
  assign wr_take = req_valid && req_ready && req_write && (req_dev == DEV_ADDR);

  always_ff @(posedge clk) begin
    in_rst_q <= !rst_pin_n;
    if (in_rst_q) AST_RESET_DISABLES: assert (!sm_enable); // R1
  end

  AST_STRAP_AUTOCLEAR: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ($past(rst_pin_n) && !serial_mode) |-> sm_enable); // R6

  AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (serial_mode && !sm_enable && !wr_take) |=> !sm_enable); // R6

  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ($past(rst_pin_n) && !serial_mode) |-> ($stable(ac_boost) && $stable(dc_boost))); // R3

  AST_APPLIED_HOLD: assert property (@(posedge clk) disable iff (!rst_pin_n)
    sm_enable |=> ($stable(ac_boost) && $stable(dc_boost))); // R7

  AST_AC_THERMO: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $past(rst_pin_n) |-> ((ac_boost & (ac_boost + 3'd1)) == 3'd0)); // R4

  AST_DC_CODE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $past(rst_pin_n) |-> (dc_boost == 3'b011 || dc_boost == 3'b101 || dc_boost == 3'b111)); // R5

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_pin_n)
    rd_take |=> rsp_valid); // R9

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_pin_n)
    rsp_valid |-> $past(rd_take)); // R8
endmodule

bind strap_cfg_ctrl strap_cfg_checker #(.DEV_ADDR(DEV_ADDR)) u_chk (
  .clk         (clk),
  .rst_pin_n   (rst_pin_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_dev     (req_dev),
  .rsp_valid   (rsp_valid),
  .serial_mode (serial_mode),
  .sm_enable   (sm_enable),
  .ac_boost    (ac_boost),
  .dc_boost    (dc_boost)
);

// File: tb/sim_strap_cfg_ctrl.sv
`timescale 1ns/1ps
module sim_strap_cfg_ctrl;
  logic       clk = 1'b0;
  logic       rst_pin_n = 1'b0;
  logic [1:0] ac_strap_lvl = 2'd0;
  logic       ac_strap_open = 1'b0;
  logic [1:0] dc_strap_lvl = 2'd1;
  logic       scl_lvl = 1'b0, sda_lvl = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_dev = 7'h2C;
  logic [7:0] req_addr = 8'h00, req_wdata = 8'h00;
  logic       req_ready, rsp_valid, serial_mode, sm_enable;
  logic [7:0] rsp_rdata;
  logic [2:0] ac_boost, dc_boost;

  int  n_vec = 0, n_bad = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  strap_cfg_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_ac(input int lvl, input bit open_pin);
    if (open_pin) return 3'b111;
    return {lvl >= 3, lvl >= 2, lvl >= 1};
  endfunction

  function automatic logic [2:0] exp_dc(input int lvl);
    if (lvl == 0) return 3'b011;
    if (lvl == 2) return 3'b111;
    return 3'b101;
  endfunction

  task automatic do_reset(input int acl, input bit aco, input int dcl, input bit s, input bit d);
    @(negedge clk);
    ac_strap_lvl = 2'(acl); ac_strap_open = aco; dc_strap_lvl = 2'(dcl);
    scl_lvl = s; sda_lvl = d; rst_pin_n = 1'b0; req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1 enable in reset", sm_enable, 0);
    chk("R1 ready in reset", req_ready, 0);
    chk("R1 ac in reset", ac_boost, exp_ac(acl, aco));
    chk("R1 dc in reset", dc_boost, exp_dc(dcl));
    @(negedge clk); rst_pin_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [6:0] dev, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_dev = dev; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic rd(input logic [6:0] dev, input logic [7:0] a, output logic v, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_dev = dev; req_addr = a;
    @(posedge clk); #1;
    v = rsp_valid; d = rsp_rdata;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic t_strap_combos;
    for (int a = 0; a < 4; a++) begin
      for (int dl = 0; dl < 4; dl++) begin
        do_reset(a, 1'b0, dl, 1'b0, 1'b0);
        chk("R2 strap mode", serial_mode, 0);
        chk("R6 auto clear", sm_enable, 1);
        chk("R4 ac code", ac_boost, exp_ac(a, 1'b0));
        chk("R5 dc code", dc_boost, exp_dc(dl));
      end
    end
    do_reset(0, 1'b1, 1, 1'b0, 1'b0);
    chk("R4 open strap", ac_boost, 3'b111);
  endtask

  task automatic t_one_line;
    do_reset(1, 1'b0, 0, 1'b1, 1'b0);
    chk("R2 scl only", serial_mode, 0);
    do_reset(1, 1'b0, 0, 1'b0, 1'b1);
    chk("R2 sda only", serial_mode, 0);
  endtask

  task automatic t_frozen;
    logic v; logic [7:0] d;
    do_reset(1, 1'b0, 0, 1'b0, 1'b0);
    @(negedge clk);
    ac_strap_lvl = 2'd3; ac_strap_open = 1'b1; dc_strap_lvl = 2'd2; scl_lvl = 1'b1; sda_lvl = 1'b1;
    repeat (5) @(posedge clk); #1;
    chk("R3 ac frozen", ac_boost, 3'b001);
    chk("R3 dc frozen", dc_boost, 3'b011);
    chk("R3 mode frozen", serial_mode, 0);
    wr(7'h2C, 8'h01, 8'h70);
    wr(7'h2C, 8'h03, 8'h01);
    @(posedge clk); #1;
    chk("R8 strap write ignored ac", ac_boost, 3'b001);
    chk("R8 strap write ignored enable", sm_enable, 1);
    rd(7'h2C, 8'h01, v, d);
    chk("R8 strap read no response", v, 0);
  endtask

  task automatic t_serial;
    logic v; logic [7:0] d;
    do_reset(0, 1'b0, 1, 1'b1, 1'b1);
    chk("R2 serial mode", serial_mode, 1);
    repeat (4) @(posedge clk); #1;
    chk("R6 hold stays set", sm_enable, 0);
    rd(7'h2C, 8'h03, v, d);
    chk("R9 read valid", v, 1);
    chk("R6 hold reads 1", d, 8'h01);
    rd(7'h2C, 8'h0E, v, d);
    chk("R5 dc readback", d, 8'h05);
    @(posedge clk); #1;
    chk("R9 response one cycle", rsp_valid, 0);
    // restart sequence
    wr(7'h2C, 8'h01, 8'h10);
    @(posedge clk); #1;
    chk("R7 ac tracks while held", ac_boost, 3'b001);
    wr(7'h2C, 8'h0E, 8'h03);
    @(posedge clk); #1;
    chk("R7 dc tracks while held", dc_boost, 3'b011);
    wr(7'h2C, 8'h03, 8'h00);
    chk("R6 cleared by write", sm_enable, 1);
    wr(7'h2C, 8'h01, 8'h70);
    @(posedge clk); #1;
    chk("R7 ac holds while running", ac_boost, 3'b001);
    rd(7'h2C, 8'h01, v, d);
    chk("R9 ac register readback", d, 8'h70);
    wr(7'h2C, 8'h03, 8'h01);
    chk("R6 set by write", sm_enable, 0);
    @(posedge clk); #1;
    chk("R7 ac applied after set", ac_boost, 3'b111);
    wr(7'h2C, 8'h03, 8'h00);
    // illegal codes and reserved bits
    wr(7'h2C, 8'h01, 8'h50);
    rd(7'h2C, 8'h01, v, d);
    chk("R10 illegal ac kept", d, 8'h70);
    wr(7'h2C, 8'h0E, 8'h04);
    rd(7'h2C, 8'h0E, v, d);
    chk("R10 illegal dc kept", d, 8'h03);
    wr(7'h2C, 8'h0E, 8'hFD);
    rd(7'h2C, 8'h0E, v, d);
    chk("R9 reserved dc bits", d, 8'h05);
    wr(7'h2C, 8'h03, 8'hFF);
    rd(7'h2C, 8'h03, v, d);
    chk("R9 reserved hold bits", d, 8'h01);
    wr(7'h2C, 8'h03, 8'h00);
    rd(7'h2C, 8'h05, v, d);
    chk("R9 undefined offset valid", v, 1);
    chk("R9 undefined offset data", d, 8'h00);
    // wrong target address
    wr(7'h2D, 8'h03, 8'h01);
    chk("R8 wrong target write dropped", sm_enable, 1);
    rd(7'h2D, 8'h03, v, d);
    chk("R8 wrong target no response", v, 0);
    // reset mid-run
    @(negedge clk);
    ac_strap_lvl = 2'd2; ac_strap_open = 1'b0; dc_strap_lvl = 2'd2; rst_pin_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 mid-run enable", sm_enable, 0);
    chk("R1 mid-run ac", ac_boost, 3'b011);
    chk("R1 mid-run dc", dc_boost, 3'b111);
    @(negedge clk); rst_pin_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_strap_combos;
    t_one_line;
    t_frozen;
    t_serial;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule